// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits beside the command port of a parallel NOR-style flash array. It watches every write cycle, and each cycle carries an address and a data word. It recognises the multi-cycle unlock patterns and the command words that follow them. When a command completes, it raises a one-cycle operation strobe with a kind code and the address and data of the closing write. The array, the pulse timing and the program and erase algorithms live elsewhere. They react to the strobe and report back through two status inputs: `busy`, which is high while an embedded operation runs, and `erase_run`, which is high while a sector erase is running.

The decoder keeps a base mode (read, autoselect, CFI query, unlock bypass) and two flags: erase-suspended and secure-region. A sequence register holds its place inside a multi-cycle command. The sequence states are:

- `SQ_IDLE`: no partial command.
- `SQ_UNL1`: the first unlock write has been seen.
- `SQ_UNL2`: both unlock writes have been seen, and the next write is the command word.
- `SQ_PROG`: waiting for the program address and data.
- `SQ_ER1`, `SQ_ER2`, `SQ_ER3`: the three steps after the erase-setup word.
- `SQ_BYP_PROG`: waiting for program address and data in bypass mode.
- `SQ_BYP_EXIT`: waiting for the second bypass-exit word.
- `SQ_SEC_EXIT`: waiting for the word that leaves the secure region.

The transitions are:

- unlock-1 (`SQ_IDLE`→`SQ_UNL1`)
- unlock-2 (`SQ_UNL1`→`SQ_UNL2`)
- command (`SQ_UNL2`→ a strobe, `SQ_PROG`, `SQ_ER1` or `SQ_SEC_EXIT`)
- erase re-unlock (`SQ_ER1`→`SQ_ER2`→`SQ_ER3`)
- erase select (`SQ_ER3`→`SQ_IDLE` with a strobe)
- bypass shortcut (`SQ_IDLE`→`SQ_BYP_PROG` or `SQ_BYP_EXIT`)
- abort (any state →`SQ_IDLE` on a mismatch, with no strobe)
- reset (any state →`SQ_IDLE` on F0)

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read), `suspended` and `secure_on` are 0, and `op_valid` is 0.
- R2: Command matching compares only address bits [10:0] and data bits [7:0]. The unlock pair is AA to address 555 followed by 55 to address 2AA. Higher address and data bits have no effect.
- R3: After the unlock pair, a write to 555 selects the command. 90 gives strobe kind 4 and mode 1 (autoselect). 20 gives kind 8 and mode 3 (bypass). 88 gives kind 6 and sets `secure_on`.
- R4: Unlock pair, then A0 to 555, then one more write gives program strobe kind 1. That strobe carries the full address and data of the fourth write.
- R5: Erase takes six writes: unlock pair, 80 to 555, unlock pair, then a final write. If the final write is 10 to 555, the strobe is kind 2 (chip erase). If it is 30 to any address, the strobe is kind 3 (sector erase) and `op_addr` is that sector address. While suspended, 80 aborts.
- R6: A write of F0 to any address, in any sequence state, gives kind 12 and cancels a partial sequence. It sets mode to read, except in bypass mode, where the mode stays 3. It leaves `suspended` unchanged, so a suspended erase returns to suspend-read.
- R7: In bypass mode, A0 to any address followed by one write gives program kind 1. 90 followed by 00 gives kind 9 and mode 0.
- R8: B0 to any address gives kind 10 and sets `suspended`, but only when `erase_run` is 1 and the decoder is not already suspended. 30 with no sequence in progress gives kind 11 and clears `suspended`, but only when suspended and `busy` is 0. Otherwise both writes are ignored.
- R9: 98 to address 55 gives kind 5 and mode 2, from mode 0 or 1 only. In mode 2, every write except F0 is ignored.
- R10: While `secure_on` is 1, the unlock pair, then 90 to 555, then 00 to any address gives kind 7 and clears `secure_on`.
- R11: A write that does not fit the next step of a partial sequence returns to `SQ_IDLE` with no strobe. Mode and flags are unchanged.
- R12: While `busy` is 1, only F0 and a valid B0 are decoded. Other writes leave every output and the partial sequence unchanged.
- R13: A strobe appears on `op_valid` in the cycle after the write that completes the command, and it lasts one cycle. `op_kind` is 0 when no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | A write cycle is present this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| busy | input | 1 | An embedded program or erase is running |
| erase_run | input | 1 | A sector erase is running (suspend is allowed) |
| op_valid | output | 1 | One-cycle decoded operation strobe |
| op_kind | output | 4 | Operation code, valid with op_valid |
| op_addr | output | ADDR_W | Address of the completing write |
| op_data | output | DATA_W | Data of the completing write |
| mode | output | 2 | 0 read, 1 autoselect, 2 CFI, 3 bypass |
| suspended | output | 1 | An erase is suspended |
| secure_on | output | 1 | The secure region is mapped |

## Verification
A wrong sequence state stays invisible until the write that should complete a command. At that write, the fault shows up as a missing strobe, a strobe that should not be there, or a wrong `op_kind`, one cycle after the write. A wrong mode or flag appears on `mode`, `suspended` or `secure_on` in the very next cycle. The bench compares every output on every clock against a behavioural model. It aims abort, busy and bypass cases at the cycles where a stale partial sequence would first show.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        OP_NONE       = 4'd0,
        OP_PROGRAM    = 4'd1,
        OP_CHIP_ERASE = 4'd2,
        OP_SECT_ERASE = 4'd3,
        OP_AUTOSEL    = 4'd4,
        OP_CFI        = 4'd5,
        OP_SEC_ENTER  = 4'd6,
        OP_SEC_EXIT   = 4'd7,
        OP_BYP_ENTER  = 4'd8,
        OP_BYP_EXIT   = 4'd9,
        OP_SUSPEND    = 4'd10,
        OP_RESUME     = 4'd11,
        OP_RESET      = 4'd12
    } op_kind_t;

    typedef enum logic [1:0] {
        MD_READ    = 2'd0,
        MD_AUTOSEL = 2'd1,
        MD_CFI     = 2'd2,
        MD_BYPASS  = 2'd3
    } mode_t;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PROG,
        SQ_ER1,
        SQ_ER2,
        SQ_ER3,
        SQ_BYP_PROG,
        SQ_BYP_EXIT,
        SQ_SEC_EXIT
    } seq_t;

    // Data codes recognised on the low byte of a write
    localparam int NUM_CODES = 13;
    typedef enum logic [3:0] {
        CI_AA, CI_55, CI_90, CI_A0, CI_80, CI_20, CI_88,
        CI_10, CI_30, CI_00, CI_F0, CI_B0, CI_98
    } code_idx_t;

    function automatic logic [7:0] code_value(input int idx);
        logic [7:0] v;
        case (idx)
            0:  v = 8'hAA;
            1:  v = 8'h55;
            2:  v = 8'h90;
            3:  v = 8'hA0;
            4:  v = 8'h80;
            5:  v = 8'h20;
            6:  v = 8'h88;
            7:  v = 8'h10;
            8:  v = 8'h30;
            9:  v = 8'h00;
            10: v = 8'hF0;
            11: v = 8'hB0;
            default: v = 8'h98;
        endcase
        return v;
    endfunction

    typedef struct packed {
        logic [NUM_CODES-1:0] dhit;   // one bit per code index
        logic                 a_555;
        logic                 a_2aa;
        logic                 a_055;
    } match_t;

endpackage

// File: rtl/fcd_cycle_match.sv
module fcd_cycle_match
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16,
    parameter int CMP_AW = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output match_t            hit
);
    localparam logic [CMP_AW-1:0] K_555 = CMP_AW'(12'h555);
    localparam logic [CMP_AW-1:0] K_2AA = CMP_AW'(12'h2AA);
    localparam logic [CMP_AW-1:0] K_055 = CMP_AW'(12'h055);

    logic [CMP_AW-1:0] a_lo;
    logic [7:0]        d_lo;

    assign a_lo = addr[CMP_AW-1:0];
    assign d_lo = data[7:0];

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
        assign hit.dhit[g] = (d_lo == code_value(g));
    end

    assign hit.a_555 = (a_lo == K_555);
    assign hit.a_2aa = (a_lo == K_2AA);
    assign hit.a_055 = (a_lo == K_055);

endmodule

// File: rtl/fcd_op_latch.sv
module fcd_op_latch
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  op_kind_t          kind_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              op_valid,
    output op_kind_t          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid <= 1'b0;
            op_kind  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            op_valid <= fire;
            op_kind  <= fire ? kind_in : OP_NONE;
            if (fire) begin
                op_addr <= addr_in;
                op_data <= data_in;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16,
    parameter int CMP_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              erase_run,
    output logic              op_valid,
    output logic [3:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [1:0]        mode,
    output logic              suspended,
    output logic              secure_on
);
    match_t   hit;
    seq_t     seq_q, seq_d;
    mode_t    mode_q, mode_d;
    logic     susp_q, susp_d;
    logic     sec_q, sec_d;
    logic     fire;
    op_kind_t kind;
    op_kind_t kind_q;

    logic d_aa, d_55, d_90, d_a0, d_80, d_20, d_88;
    logic d_10, d_30, d_00, d_f0, d_b0, d_98;
    logic can_suspend, can_resume;

    fcd_cycle_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_AW(CMP_AW)) u_match (
        .addr (wr_addr),
        .data (wr_data),
        .hit  (hit)
    );

    assign d_aa = hit.dhit[CI_AA];
    assign d_55 = hit.dhit[CI_55];
    assign d_90 = hit.dhit[CI_90];
    assign d_a0 = hit.dhit[CI_A0];
    assign d_80 = hit.dhit[CI_80];
    assign d_20 = hit.dhit[CI_20];
    assign d_88 = hit.dhit[CI_88];
    assign d_10 = hit.dhit[CI_10];
    assign d_30 = hit.dhit[CI_30];
    assign d_00 = hit.dhit[CI_00];
    assign d_f0 = hit.dhit[CI_F0];
    assign d_b0 = hit.dhit[CI_B0];
    assign d_98 = hit.dhit[CI_98];

    assign can_suspend = d_b0 && erase_run && !susp_q;
    assign can_resume  = d_30 && susp_q && !busy;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q  <= SQ_IDLE;
            mode_q <= MD_READ;
            susp_q <= 1'b0;
            sec_q  <= 1'b0;
        end else begin
            seq_q  <= seq_d;
            mode_q <= mode_d;
            susp_q <= susp_d;
            sec_q  <= sec_d;
        end
    end

    // Next state and strobe decision
    always_comb begin
        seq_d  = seq_q;
        mode_d = mode_q;
        susp_d = susp_q;
        sec_d  = sec_q;
        fire   = 1'b0;
        kind   = OP_NONE;
        if (wr_en) begin
            if (d_f0) begin
                fire  = 1'b1;
                kind  = OP_RESET;
                seq_d = SQ_IDLE;
                if (mode_q != MD_BYPASS) mode_d = MD_READ;
            end else if (busy) begin
                if (can_suspend) begin
                    fire   = 1'b1;
                    kind   = OP_SUSPEND;
                    susp_d = 1'b1;
                    seq_d  = SQ_IDLE;
                end
            end else begin
                unique case (seq_q)
                    SQ_IDLE: begin
                        if (mode_q == MD_CFI) begin
                            seq_d = SQ_IDLE;
                        end else if (can_suspend) begin
                            fire   = 1'b1;
                            kind   = OP_SUSPEND;
                            susp_d = 1'b1;
                        end else if (can_resume) begin
                            fire   = 1'b1;
                            kind   = OP_RESUME;
                            susp_d = 1'b0;
                        end else if (d_98 && hit.a_055 &&
                                     (mode_q == MD_READ || mode_q == MD_AUTOSEL)) begin
                            fire   = 1'b1;
                            kind   = OP_CFI;
                            mode_d = MD_CFI;
                        end else if (mode_q == MD_BYPASS) begin
                            if (d_a0)      seq_d = SQ_BYP_PROG;
                            else if (d_90) seq_d = SQ_BYP_EXIT;
                        end else if (d_aa && hit.a_555) begin
                            seq_d = SQ_UNL1;
                        end
                    end
                    SQ_UNL1: seq_d = (d_55 && hit.a_2aa) ? SQ_UNL2 : SQ_IDLE;
                    SQ_UNL2: begin
                        seq_d = SQ_IDLE;
                        if (hit.a_555) begin
                            if (d_90) begin
                                if (sec_q) begin
                                    seq_d = SQ_SEC_EXIT;
                                end else begin
                                    fire   = 1'b1;
                                    kind   = OP_AUTOSEL;
                                    mode_d = MD_AUTOSEL;
                                end
                            end else if (d_a0) begin
                                seq_d = SQ_PROG;
                            end else if (d_80 && !susp_q) begin
                                seq_d = SQ_ER1;
                            end else if (d_20) begin
                                fire   = 1'b1;
                                kind   = OP_BYP_ENTER;
                                mode_d = MD_BYPASS;
                            end else if (d_88) begin
                                fire  = 1'b1;
                                kind  = OP_SEC_ENTER;
                                sec_d = 1'b1;
                            end
                        end
                    end
                    SQ_PROG, SQ_BYP_PROG: begin
                        fire  = 1'b1;
                        kind  = OP_PROGRAM;
                        seq_d = SQ_IDLE;
                    end
                    SQ_ER1: seq_d = (d_aa && hit.a_555) ? SQ_ER2 : SQ_IDLE;
                    SQ_ER2: seq_d = (d_55 && hit.a_2aa) ? SQ_ER3 : SQ_IDLE;
                    SQ_ER3: begin
                        seq_d = SQ_IDLE;
                        if (d_10 && hit.a_555) begin
                            fire = 1'b1;
                            kind = OP_CHIP_ERASE;
                        end else if (d_30) begin
                            fire = 1'b1;
                            kind = OP_SECT_ERASE;
                        end
                    end
                    SQ_BYP_EXIT: begin
                        seq_d = SQ_IDLE;
                        if (d_00) begin
                            fire   = 1'b1;
                            kind   = OP_BYP_EXIT;
                            mode_d = MD_READ;
                        end
                    end
                    SQ_SEC_EXIT: begin
                        seq_d = SQ_IDLE;
                        if (d_00) begin
                            fire  = 1'b1;
                            kind  = OP_SEC_EXIT;
                            sec_d = 1'b0;
                        end
                    end
                    default: seq_d = SQ_IDLE;
                endcase
            end
        end
    end

    // Output registers
    fcd_op_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .kind_in  (kind),
        .addr_in  (wr_addr),
        .data_in  (wr_data),
        .op_valid (op_valid),
        .op_kind  (kind_q),
        .op_addr  (op_addr),
        .op_data  (op_data)
    );

    assign op_kind   = kind_q;
    assign mode      = mode_q;
    assign suspended = susp_q;
    assign secure_on = sec_q;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
    import flash_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       busy,
    input logic       op_valid,
    input logic [3:0] op_kind,
    input logic [1:0] mode,
    input logic       suspended,
    input logic       secure_on
);
    // R13: a strobe always follows a write
    a_r13_strobe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(wr_en));

    // R13: kind is zero without a strobe
    a_r13_kind_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> op_kind == 4'd0);

    // R12: during busy only reset or suspend may strobe
    a_r12_busy_filter: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && $past(busy)) |-> (op_kind == 4'd12 || op_kind == 4'd10));

    // R11: mode changes only alongside a strobe
    a_r11_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> $stable(mode));

    // R11: flags change only alongside a strobe
    a_r11_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> ($stable(suspended) && $stable(secure_on)));

    // R9: CFI strobe lands in CFI mode
    a_r9_cfi_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 4'd5) |-> mode == 2'd2);

    // R8: suspend and resume flag direction
    a_r8_suspend_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 4'd10) |-> (suspended && !$past(suspended)));

    a_r8_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 4'd11) |-> (!suspended && $past(suspended)));

    // R10: secure exit clears the flag
    a_r10_sec_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 4'd7) |-> !secure_on);

    // R6: reset leaves read or bypass mode, keeps suspend flag
    a_r6_reset_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 4'd12) |-> ((mode == 2'd0 || mode == 2'd3) && $stable(suspended)));

endmodule

bind flash_cmd_decoder fcd_checker u_fcd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .busy      (busy),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .mode      (mode),
    .suspended (suspended),
    .secure_on (secure_on)
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
    localparam int AW = 22;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          busy = 1'b0;
    logic          erase_run = 1'b0;
    logic          op_valid;
    logic [3:0]    op_kind;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;
    logic [1:0]    mode;
    logic          suspended;
    logic          secure_on;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference state
    int  r_stage = 0;   // progress count within a sequence
    string r_path = ""; // which command family the partial sequence belongs to
    int  r_mode = 0;
    bit  r_susp = 0;
    bit  r_sec = 0;
    bit  e_v = 0;
    int  e_k = 0;
    logic [AW-1:0] e_a = '0;
    logic [DW-1:0] e_d = '0;

    always #4 clk = ~clk;   // 125 MHz

    flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .CMP_AW(11)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .erase_run(erase_run),
        .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
        .op_data(op_data), .mode(mode), .suspended(suspended),
        .secure_on(secure_on)
    );

    task automatic emit(input int k, input logic [AW-1:0] a, input logic [DW-1:0] d);
        e_v = 1; e_k = k; e_a = a; e_d = d;
    endtask

    task automatic drop();
        r_stage = 0; r_path = "";
    endtask

    task automatic model(input bit en, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit bz, input bit er);
        logic [7:0]  c;
        logic [10:0] lo;
        c = d[7:0];
        lo = a[10:0];
        e_v = 0; e_k = 0;
        if (!en) return;
        if (c == 8'hF0) begin
            emit(12, a, d); drop();
            if (r_mode != 3) r_mode = 0;
            return;
        end
        if (bz) begin
            if (c == 8'hB0 && er && !r_susp) begin emit(10, a, d); r_susp = 1; drop(); end
            return;
        end
        if (r_stage == 0) begin
            if (r_mode == 2) return;
            if (c == 8'hB0 && er && !r_susp) begin emit(10, a, d); r_susp = 1; end
            else if (c == 8'h30 && r_susp) begin emit(11, a, d); r_susp = 0; end
            else if (c == 8'h98 && lo == 11'h055 && r_mode < 2) begin emit(5, a, d); r_mode = 2; end
            else if (r_mode == 3) begin
                if (c == 8'hA0) begin r_stage = 1; r_path = "bprog"; end
                else if (c == 8'h90) begin r_stage = 1; r_path = "bexit"; end
            end else if (c == 8'hAA && lo == 11'h555) begin r_stage = 1; r_path = "unl"; end
            return;
        end
        if (r_path == "bprog") begin emit(1, a, d); drop(); return; end
        if (r_path == "bexit") begin
            if (c == 8'h00) begin emit(9, a, d); r_mode = 0; end
            drop(); return;
        end
        if (r_path == "prog") begin emit(1, a, d); drop(); return; end
        if (r_path == "sexit") begin
            if (c == 8'h00) begin emit(7, a, d); r_sec = 0; end
            drop(); return;
        end
        if (r_path == "unl" && r_stage == 1) begin
            if (c == 8'h55 && lo == 11'h2AA) r_stage = 2; else drop();
            return;
        end
        if (r_path == "unl" && r_stage == 2) begin
            drop();
            if (lo != 11'h555) return;
            case (c)
                8'h90: if (r_sec) begin r_stage = 1; r_path = "sexit"; end
                       else begin emit(4, a, d); r_mode = 1; end
                8'hA0: begin r_stage = 1; r_path = "prog"; end
                8'h80: if (!r_susp) begin r_stage = 1; r_path = "erase"; end
                8'h20: begin emit(8, a, d); r_mode = 3; end
                8'h88: begin emit(6, a, d); r_sec = 1; end
                default: ;
            endcase
            return;
        end
        if (r_path == "erase") begin
            if (r_stage == 1) begin
                if (c == 8'hAA && lo == 11'h555) r_stage = 2; else drop();
            end else if (r_stage == 2) begin
                if (c == 8'h55 && lo == 11'h2AA) r_stage = 3; else drop();
            end else begin
                if (c == 8'h10 && lo == 11'h555) emit(2, a, d);
                else if (c == 8'h30) emit(3, a, d);
                drop();
            end
        end
    endtask

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "op_valid", op_valid, e_v);
        chk(tag, "op_kind", op_kind, e_v ? e_k : 0);
        if (e_v) begin
            chk(tag, "op_addr", op_addr, e_a);
            chk(tag, "op_data", op_data, e_d);
        end
        chk(tag, "mode", mode, r_mode);
        chk(tag, "suspended", suspended, r_susp);
        chk(tag, "secure_on", secure_on, r_sec);
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit en, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input string tag);
        wr_en = en; wr_addr = a; wr_data = d;
        @(posedge clk);
        model(en, a, d, busy, erase_run);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        step(1'b1, a, d, tag);
        step(1'b0, '0, '0, tag);
    endtask

    task automatic unlock(input string tag);
        wr(22'h000555, 16'h00AA, tag);
        wr(22'h0002AA, 16'h0055, tag);
    endtask

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        step(0, '0, '0, "R1");
        step(0, '0, '0, "R1");

        // R2: upper address/data bits set, autoselect entry (R3)
        wr(22'h3FF555, 16'hC3AA, "R2");
        wr(22'h2A72AA, 16'h7755, "R2");
        wr(22'h155555, 16'hEE90, "R3");
        // R9: CFI from autoselect, then writes ignored in CFI
        wr(22'h000055, 16'h0098, "R9");
        unlock("R9");
        wr(22'h000555, 16'h0090, "R9");
        wr(22'h012345, 16'h00F0, "R6");
        wr(22'h000055, 16'h0098, "R9");
        wr(22'h000000, 16'h00F0, "R6");

        // R4: program, back-to-back writes
        step(1, 22'h000555, 16'h00AA, "R4");
        step(1, 22'h0002AA, 16'h0055, "R4");
        step(1, 22'h000555, 16'h00A0, "R4");
        step(1, 22'h2ABCDE, 16'hBEEF, "R4");
        step(1, 22'h000001, 16'h00F0, "R13");
        step(0, '0, '0, "R13");

        // R5: chip and sector erase
        unlock("R5"); wr(22'h000555, 16'h0080, "R5");
        unlock("R5"); wr(22'h000555, 16'h0010, "R5");
        unlock("R5"); wr(22'h000555, 16'h0080, "R5");
        unlock("R5"); wr(22'h1F8000, 16'h0030, "R5");

        // R11: aborts
        wr(22'h000555, 16'h00AA, "R11"); wr(22'h0002AA, 16'h0056, "R11");
        wr(22'h0002AA, 16'h0055, "R11");
        unlock("R11"); wr(22'h000555, 16'h0077, "R11");
        unlock("R11"); wr(22'h000554, 16'h0090, "R11");
        unlock("R11"); wr(22'h000555, 16'h0080, "R11"); wr(22'h000555, 16'h00AB, "R11");
        unlock("R11"); wr(22'h000555, 16'h0080, "R11"); unlock("R11"); wr(22'h000554, 16'h0010, "R11");
        // R6: reset mid-sequence
        wr(22'h000555, 16'h00AA, "R6"); wr(22'h00ABCD, 16'h00F0, "R6");
        wr(22'h0002AA, 16'h0055, "R6");

        // R7: unlock bypass
        unlock("R3"); wr(22'h000555, 16'h0020, "R3");
        wr(22'h000123, 16'h00A0, "R7"); wr(22'h0C0FFE, 16'h1234, "R7");
        wr(22'h000000, 16'h00F0, "R6");
        wr(22'h000000, 16'h0090, "R7"); wr(22'h000000, 16'h0011, "R7");
        wr(22'h000055, 16'h0098, "R9");
        wr(22'h000000, 16'h0090, "R7"); wr(22'h000000, 16'h0000, "R7");

        // R10: secure region
        unlock("R3"); wr(22'h000555, 16'h0088, "R3");
        unlock("R10"); wr(22'h000555, 16'h0090, "R10"); wr(22'h000777, 16'h0000, "R10");
        unlock("R10"); wr(22'h000555, 16'h0090, "R10");
        wr(22'h000000, 16'h00F0, "R6");

        // R8 / R12: suspend and resume
        wr(22'h000000, 16'h00B0, "R8");
        wr(22'h000000, 16'h0030, "R8");
        busy = 1; erase_run = 1;
        step(0, '0, '0, "R12");
        wr(22'h000555, 16'h00AA, "R12");
        wr(22'h000055, 16'h0098, "R12");
        wr(22'h000000, 16'h0030, "R12");
        wr(22'h001000, 16'h00B0, "R8");
        busy = 0; erase_run = 0;
        step(0, '0, '0, "R8");
        wr(22'h000000, 16'h00B0, "R8");
        unlock("R5"); wr(22'h000555, 16'h0080, "R5"); wr(22'h000555, 16'h00AA, "R5");
        unlock("R3"); wr(22'h000555, 16'h0090, "R3");
        wr(22'h000000, 16'h00F0, "R6");
        unlock("R4"); wr(22'h000555, 16'h00A0, "R4"); wr(22'h000042, 16'h5A5A, "R4");
        busy = 1;
        step(0, '0, '0, "R12");
        wr(22'h000000, 16'h0030, "R8");
        busy = 0;
        step(0, '0, '0, "R8");
        wr(22'h000000, 16'h0030, "R8");
        wr(22'h000000, 16'h0030, "R8");

        // R12: busy write mid-sequence keeps the partial sequence
        wr(22'h000555, 16'h00AA, "R12");
        busy = 1;
        step(0, '0, '0, "R12");
        wr(22'h0002AA, 16'h0013, "R12");
        busy = 0;
        step(0, '0, '0, "R12");
        wr(22'h0002AA, 16'h0055, "R12");
        wr(22'h000555, 16'h0090, "R12");
        wr(22'h000000, 16'h00F0, "R6");
        repeat (3) step(0, '0, '0, "R13");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule